// File: doc/BRIEF.md
# Stride Prefetcher with Stream Buffer

This block sits next to a data cache and watches the cache's demand misses, one block address at a time. Each demand miss that the block cannot serve itself becomes a demand memory request. The block also predicts which block the program will touch next and sends a prefetch request for it. It can predict in two ways. In learned-stride operation it tracks the distance between consecutive miss addresses and makes a prediction once the same nonzero distance has repeated. In next-block operation every miss predicts the following block.

Prefetched data never goes straight into the cache. Fills for prefetched blocks land in a small side buffer that tracks, for each entry, whether the data has arrived and whether a demand reference is waiting for it. A block leaves the buffer for the cache only when a demand miss references it, so a wrong guess cannot displace a useful cache line. When the buffer is full, the oldest entry is replaced.

Demand requests always take priority over prefetch traffic. A predicted block that is already in the cache or already in the buffer produces no memory request.

Top module: `stride_prefetch_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all buffer entries and the stride history. After reset `dreq_valid`, `preq_valid` and `xfer_valid` are 0 and `miss_ready` is 1. The first misses after reset never produce a prefetch, whatever stride the misses before reset had.
- R2: An accepted miss whose block is not in the buffer raises `dreq_valid` with that block in the next cycle. `dreq_blk` is held stable while `dreq_ready` is 0.
- R3: With `next_blk_mode`=1, an accepted miss on block X produces a demand request for X and then a prefetch request for X+1.
- R4: With `next_blk_mode`=0, a miss on block X produces a prefetch of X+n when the difference to the previous miss is n, n is nonzero, and the previous difference was also n. Differences wrap modulo 2^BLK_W.
- R5: A zero difference, or a difference unequal to the previous one, produces no prefetch. A new miss replaces any unissued prediction.
- R6: `preq_valid` is never 1 while `dreq_valid` is 1.
- R7: A prediction whose block is reported present by `pf_probe_hit` (probe address on `pf_probe_blk`) or is held in any buffer entry is dropped and never requested.
- R8: An accepted prefetch allocates a buffer entry. Its fill on `fill_valid`/`fill_blk` produces no transfer toward the cache until a demand miss references the block.
- R9: A miss on a buffered block whose data has arrived raises no demand request. `xfer_valid` is 1 with that block in the next cycle, for one cycle.
- R10: A miss on a buffered block whose data has not yet arrived raises no demand request. `xfer_valid` carries the block in the cycle after its fill.
- R11: With all N_ENT entries in use, a new prefetch replaces the entry allocated earliest. A later miss on the replaced block raises a demand request, and the other entries stay buffered.
- R12: `miss_ready` is 0 exactly while a demand request is pending and `dreq_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| next_blk_mode | input | 1 | 1: predict X+1 on every miss; 0: learned stride |
| miss_valid | input | 1 | Demand miss present |
| miss_blk | input | BLK_W | Demand miss block address |
| miss_ready | output | 1 | Miss can be taken this cycle |
| dreq_valid | output | 1 | Demand memory request |
| dreq_blk | output | BLK_W | Demand request block |
| dreq_ready | input | 1 | Memory queue takes demand request |
| preq_valid | output | 1 | Prefetch memory request |
| preq_blk | output | BLK_W | Prefetch request block |
| preq_ready | input | 1 | Memory queue takes prefetch request |
| pf_probe_blk | output | BLK_W | Predicted block, for a cache presence lookup |
| pf_probe_hit | input | 1 | Cache holds `pf_probe_blk` (same cycle) |
| fill_valid | input | 1 | Prefetch fill returns |
| fill_blk | input | BLK_W | Block of returning fill |
| xfer_valid | output | 1 | Buffered block moves to the cache |
| xfer_blk | output | BLK_W | Block being moved |

## Verification
The hardest case to reach is a demand miss that lands on an entry whose fill is still outstanding. The stimulus grants a learned prefetch, withholds its fill, and only then presents the miss, so the bench sees no demand request and a transfer one cycle after the late fill. Dropping a prediction because the block is in the buffer is reached through next-block operation aimed one block below a pending entry. Replacement order is exercised by granting five next-block prefetches into four entries and then missing on the first and second predicted blocks.

// File: rtl/spf_pkg.sv
package spf_pkg;
   typedef enum logic {PF_LEARNED = 1'b0, PF_NEXT = 1'b1} pf_mode_e;

   function automatic logic [63:0] blk_add(input logic [63:0] a, input logic [63:0] b);
      return a + b;
   endfunction
endpackage

// File: rtl/spf_stride_det.sv
module spf_stride_det #(
   parameter int BLK_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             obs_go,
   input  logic [BLK_W-1:0] obs_blk,
   input  logic             next_mode,
   output logic             gen,
   output logic [BLK_W-1:0] tgt
);
   import spf_pkg::*;

   logic [BLK_W-1:0] last_blk, last_delta, delta;
   logic             have_last, have_delta;
   pf_mode_e         mode;
   logic [63:0]      sum;

   assign delta = obs_blk - last_blk;
   assign mode  = next_mode ? PF_NEXT : PF_LEARNED;

   always_comb begin
      if (mode == PF_NEXT) begin
         gen = obs_go;
         sum = blk_add(64'(obs_blk), 64'd1);
      end else begin
         gen = obs_go && have_delta && (delta == last_delta) && (delta != '0);
         sum = blk_add(64'(obs_blk), 64'(delta));
      end
   end
   assign tgt = sum[BLK_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) begin
         last_blk   <= '0;
         last_delta <= '0;
         have_last  <= 1'b0;
         have_delta <= 1'b0;
      end else if (obs_go) begin
         last_blk   <= obs_blk;
         last_delta <= delta;
         have_last  <= 1'b1;
         have_delta <= have_last;
      end
   end
endmodule

// File: rtl/spf_stream_buf.sv
module spf_stream_buf #(
   parameter int BLK_W = 32,
   parameter int N_ENT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [BLK_W-1:0] lkp_blk,
   output logic             lkp_hit,
   input  logic             dm_go,
   input  logic [BLK_W-1:0] dm_blk,
   output logic             dm_hit,
   input  logic             fill_go,
   input  logic [BLK_W-1:0] fill_blk,
   input  logic             alloc_go,
   input  logic [BLK_W-1:0] alloc_blk,
   output logic             alloc_ok,
   output logic             xfer_valid,
   output logic [BLK_W-1:0] xfer_blk
);
   localparam int RW = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam logic [RW-1:0] OLDEST = RW'(N_ENT - 1);

   logic [N_ENT-1:0] vld, pend, want;
   logic [N_ENT-1:0] n_vld, n_pend, n_want;
   logic [BLK_W-1:0] blk   [N_ENT];
   logic [BLK_W-1:0] n_blk [N_ENT];
   logic [RW-1:0]    rank  [N_ENT];
   logic [RW-1:0]    n_rank[N_ENT];

   logic [N_ENT-1:0] dm_match, lkp_match, fill_match, ready_vec, old_vec;
   logic [RW-1:0]    xsel, vic, slot;
   logic             found;

   for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
      assign dm_match[g]   = vld[g] && (blk[g] == dm_blk);
      assign lkp_match[g]  = vld[g] && (blk[g] == lkp_blk);
      assign fill_match[g] = vld[g] && pend[g] && (blk[g] == fill_blk);
      assign ready_vec[g]  = vld[g] && !pend[g] && want[g];
      assign old_vec[g]    = vld[g] && (rank[g] == OLDEST);
   end

   assign dm_hit  = |dm_match;
   assign lkp_hit = |lkp_match;

   always_comb begin
      xsel       = '0;
      xfer_valid = 1'b0;
      for (int i = 0; i < N_ENT; i++) begin
         if (!xfer_valid && ready_vec[i]) begin
            xsel       = RW'(i);
            xfer_valid = 1'b1;
         end
      end
   end
   assign xfer_blk = blk[xsel];

   always_comb begin
      vic = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (old_vec[i]) vic = RW'(i);
      end
   end

   // the oldest entry may be replaced only if no demand waits on it
   assign alloc_ok = !(&vld) || !(want[vic] || (dm_go && dm_match[vic]));

   always_comb begin
      n_vld  = vld;
      n_pend = pend;
      n_want = want;
      n_blk  = blk;
      n_rank = rank;
      for (int i = 0; i < N_ENT; i++) begin
         if (dm_go && dm_match[i])     n_want[i] = 1'b1;
         if (fill_go && fill_match[i]) n_pend[i] = 1'b0;
      end
      if (xfer_valid) begin
         for (int i = 0; i < N_ENT; i++) begin
            if (vld[i] && (rank[i] > rank[xsel])) n_rank[i] = rank[i] - RW'(1);
         end
         n_vld[xsel]  = 1'b0;
         n_want[xsel] = 1'b0;
      end
      slot  = '0;
      found = 1'b0;
      for (int i = 0; i < N_ENT; i++) begin
         if (!found && !n_vld[i]) begin
            slot  = RW'(i);
            found = 1'b1;
         end
      end
      for (int i = 0; i < N_ENT; i++) begin
         if (!found && (n_rank[i] == OLDEST)) begin
            slot  = RW'(i);
            found = 1'b1;
         end
      end
      if (alloc_go) begin
         for (int i = 0; i < N_ENT; i++) begin
            if (n_vld[i] && (RW'(i) != slot)) n_rank[i] = n_rank[i] + RW'(1);
         end
         n_vld[slot]  = 1'b1;
         n_pend[slot] = 1'b1;
         n_want[slot] = 1'b0;
         n_blk[slot]  = alloc_blk;
         n_rank[slot] = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         vld  <= '0;
         pend <= '0;
         want <= '0;
         for (int i = 0; i < N_ENT; i++) begin
            blk[i]  <= '0;
            rank[i] <= '0;
         end
      end else begin
         vld  <= n_vld;
         pend <= n_pend;
         want <= n_want;
         for (int i = 0; i < N_ENT; i++) begin
            blk[i]  <= n_blk[i];
            rank[i] <= n_rank[i];
         end
      end
   end
endmodule

// File: rtl/spf_issue.sv
module spf_issue #(
   parameter int BLK_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             miss_go,
   input  logic [BLK_W-1:0] miss_blk,
   input  logic             miss_in_buf,
   input  logic             gen,
   input  logic [BLK_W-1:0] tgt,
   input  logic             pf_present,
   input  logic             alloc_ok,
   input  logic             dreq_ready,
   input  logic             preq_ready,
   output logic             miss_ready,
   output logic             dreq_valid,
   output logic [BLK_W-1:0] dreq_blk,
   output logic             preq_valid,
   output logic [BLK_W-1:0] cand_blk
);
   logic pf_pend;

   assign miss_ready = !dreq_valid || dreq_ready;
   assign preq_valid = pf_pend && !pf_present && !dreq_valid && alloc_ok;

   always_ff @(posedge clk) begin
      if (rst) begin
         dreq_valid <= 1'b0;
         dreq_blk   <= '0;
         pf_pend    <= 1'b0;
         cand_blk   <= '0;
      end else begin
         if (miss_go && !miss_in_buf) begin
            dreq_valid <= 1'b1;
            dreq_blk   <= miss_blk;
         end else if (dreq_ready) begin
            dreq_valid <= 1'b0;
         end
         if (miss_go) begin
            pf_pend <= gen;
            if (gen) cand_blk <= tgt;
         end else if ((preq_valid && preq_ready) || pf_present) begin
            pf_pend <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/stride_prefetch_unit.sv
module stride_prefetch_unit #(
   parameter int BLK_W = 32,
   parameter int N_ENT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             next_blk_mode,
   input  logic             miss_valid,
   input  logic [BLK_W-1:0] miss_blk,
   output logic             miss_ready,
   output logic             dreq_valid,
   output logic [BLK_W-1:0] dreq_blk,
   input  logic             dreq_ready,
   output logic             preq_valid,
   output logic [BLK_W-1:0] preq_blk,
   input  logic             preq_ready,
   output logic [BLK_W-1:0] pf_probe_blk,
   input  logic             pf_probe_hit,
   input  logic             fill_valid,
   input  logic [BLK_W-1:0] fill_blk,
   output logic             xfer_valid,
   output logic [BLK_W-1:0] xfer_blk
);
   if (BLK_W < 4 || BLK_W > 64) begin : g_bad_width
      $error("stride_prefetch_unit: BLK_W must be within 4..64");
   end
   if (N_ENT < 2 || N_ENT > 64) begin : g_bad_depth
      $error("stride_prefetch_unit: N_ENT must be within 2..64");
   end

   logic             miss_go, miss_in_buf, gen, lkp_hit, pf_present, alloc_ok;
   logic [BLK_W-1:0] tgt, cand_blk;

   assign miss_go      = miss_valid && miss_ready;
   assign pf_present   = pf_probe_hit || lkp_hit;
   assign pf_probe_blk = cand_blk;
   assign preq_blk     = cand_blk;

   spf_stride_det #(.BLK_W(BLK_W)) u_det (
      .clk(clk), .rst(rst), .obs_go(miss_go), .obs_blk(miss_blk),
      .next_mode(next_blk_mode), .gen(gen), .tgt(tgt)
   );

   spf_stream_buf #(.BLK_W(BLK_W), .N_ENT(N_ENT)) u_buf (
      .clk(clk), .rst(rst),
      .lkp_blk(cand_blk), .lkp_hit(lkp_hit),
      .dm_go(miss_go), .dm_blk(miss_blk), .dm_hit(miss_in_buf),
      .fill_go(fill_valid), .fill_blk(fill_blk),
      .alloc_go(preq_valid && preq_ready), .alloc_blk(cand_blk), .alloc_ok(alloc_ok),
      .xfer_valid(xfer_valid), .xfer_blk(xfer_blk)
   );

   spf_issue #(.BLK_W(BLK_W)) u_iss (
      .clk(clk), .rst(rst), .miss_go(miss_go), .miss_blk(miss_blk),
      .miss_in_buf(miss_in_buf), .gen(gen), .tgt(tgt), .pf_present(pf_present),
      .alloc_ok(alloc_ok), .dreq_ready(dreq_ready), .preq_ready(preq_ready),
      .miss_ready(miss_ready), .dreq_valid(dreq_valid), .dreq_blk(dreq_blk),
      .preq_valid(preq_valid), .cand_blk(cand_blk)
   );
endmodule

// File: rtl/spf_checker.sv
module spf_checker #(
   parameter int BLK_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             dreq_valid,
   input logic             dreq_ready,
   input logic [BLK_W-1:0] dreq_blk,
   input logic             preq_valid,
   input logic             pf_probe_hit,
   input logic             miss_go,
   input logic             miss_buf_hit
);
   // R6
   a_r6_demand_first: assert property (@(posedge clk) disable iff (rst)
      !(preq_valid && dreq_valid));

   // R2
   a_r2_dreq_hold: assert property (@(posedge clk) disable iff (rst)
      (dreq_valid && !dreq_ready) |=> (dreq_valid && $stable(dreq_blk)));

   // R7
   a_r7_present_no_req: assert property (@(posedge clk) disable iff (rst)
      preq_valid |-> !pf_probe_hit);

   // R9 / R10
   a_r9_buf_hit_no_dreq: assert property (@(posedge clk) disable iff (rst)
      (miss_go && miss_buf_hit) |=> !dreq_valid);
endmodule

bind stride_prefetch_unit spf_checker #(.BLK_W(BLK_W)) u_chk (
   .clk(clk), .rst(rst), .dreq_valid(dreq_valid), .dreq_ready(dreq_ready),
   .dreq_blk(dreq_blk), .preq_valid(preq_valid), .pf_probe_hit(pf_probe_hit),
   .miss_go(miss_go), .miss_buf_hit(miss_in_buf)
);

// File: tb/stride_prefetch_unit_test.sv
module stride_prefetch_unit_test;
   localparam int CLK_PERIOD = 10;
   localparam int BW = 32;

   typedef struct packed {
      logic [31:0] blk;
      logic        nm;
      logic        pf;
      logic [31:0] tgt;
   } vec_t;

   localparam int NV = 13;
   localparam vec_t VT [NV] = '{
      '{32'd100, 1'b0, 1'b0, 32'd0},
      '{32'd104, 1'b0, 1'b0, 32'd0},
      '{32'd108, 1'b0, 1'b1, 32'd112},
      '{32'd112, 1'b0, 1'b1, 32'd116},
      '{32'd113, 1'b0, 1'b0, 32'd0},
      '{32'd114, 1'b0, 1'b1, 32'd115},
      '{32'd114, 1'b0, 1'b0, 32'd0},
      '{32'd110, 1'b0, 1'b0, 32'd0},
      '{32'd106, 1'b0, 1'b1, 32'd102},
      '{32'd200, 1'b1, 1'b1, 32'd201},
      '{32'd50,  1'b1, 1'b1, 32'd51},
      '{32'd40,  1'b0, 1'b0, 32'd0},
      '{32'd30,  1'b0, 1'b1, 32'd20}
   };

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          next_blk_mode = 1'b0;
   logic          miss_valid = 1'b0;
   logic [BW-1:0] miss_blk = '0;
   logic          miss_ready;
   logic          dreq_valid;
   logic [BW-1:0] dreq_blk;
   logic          dreq_ready = 1'b0;
   logic          preq_valid;
   logic [BW-1:0] preq_blk;
   logic          preq_ready = 1'b0;
   logic [BW-1:0] pf_probe_blk;
   logic          pf_probe_hit = 1'b0;
   logic          fill_valid = 1'b0;
   logic [BW-1:0] fill_blk = '0;
   logic          xfer_valid;
   logic [BW-1:0] xfer_blk;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stride_prefetch_unit #(.BLK_W(BW), .N_ENT(4)) uut (
      .clk(clk), .rst(rst), .next_blk_mode(next_blk_mode),
      .miss_valid(miss_valid), .miss_blk(miss_blk), .miss_ready(miss_ready),
      .dreq_valid(dreq_valid), .dreq_blk(dreq_blk), .dreq_ready(dreq_ready),
      .preq_valid(preq_valid), .preq_blk(preq_blk), .preq_ready(preq_ready),
      .pf_probe_blk(pf_probe_blk), .pf_probe_hit(pf_probe_hit),
      .fill_valid(fill_valid), .fill_blk(fill_blk),
      .xfer_valid(xfer_valid), .xfer_blk(xfer_blk)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_miss(input logic [BW-1:0] b, input logic nm);
      miss_valid    = 1'b1;
      miss_blk      = b;
      next_blk_mode = nm;
      step();
      miss_valid    = 1'b0;
   endtask

   task automatic accept_dreq();
      dreq_ready = 1'b1;
      step();
      dreq_ready = 1'b0;
   endtask

   task automatic accept_preq();
      preq_ready = 1'b1;
      step();
      preq_ready = 1'b0;
   endtask

   task automatic do_fill(input logic [BW-1:0] b);
      fill_valid = 1'b1;
      fill_blk   = b;
      step();
      fill_valid = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step();
      step();
      rst = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset();
      // R1 reset state
      chk("R1 dreq_valid", dreq_valid, 0);
      chk("R1 preq_valid", preq_valid, 0);
      chk("R1 xfer_valid", xfer_valid, 0);
      chk("R1 miss_ready", miss_ready, 1);

      // vector table: stride learning, next-block, priority, back-pressure
      for (int v = 0; v < NV; v++) begin
         string tag;
         tag = VT[v].nm ? "R3" : (VT[v].pf ? "R4" : "R5");
         do_miss(VT[v].blk, VT[v].nm);
         chk("R2 dreq_valid", dreq_valid, 1);
         chk("R2 dreq_blk", dreq_blk, VT[v].blk);
         chk("R12 miss_ready low", miss_ready, 0);
         chk("R6 preq masked", preq_valid, 0);
         step();
         chk("R2 dreq_blk held", dreq_blk, VT[v].blk);
         dreq_ready = 1'b1;
         #1;
         chk("R12 miss_ready high", miss_ready, 1);
         step();
         dreq_ready = 1'b0;
         chk("R2 dreq cleared", dreq_valid, 0);
         chk({tag, " preq_valid"}, preq_valid, VT[v].pf);
         if (VT[v].pf) chk({tag, " preq_blk"}, preq_blk, VT[v].tgt);
      end

      // R1: history is cleared by reset (20 would continue the -10 stride)
      do_reset();
      do_miss(20, 0);
      accept_dreq();
      chk("R1 no prefetch after reset", preq_valid, 0);

      // R7: prediction present in the cache is dropped
      pf_probe_hit = 1'b1;
      do_miss(0, 0);
      accept_dreq();
      do_miss(8, 0);
      accept_dreq();
      do_miss(16, 0);
      accept_dreq();
      chk("R7 cache-present no preq", preq_valid, 0);
      pf_probe_hit = 1'b0;
      #1;
      chk("R7 dropped prediction stays dropped", preq_valid, 0);

      // R4 then R8: granted prefetch, fill does not transfer
      do_miss(24, 0);
      accept_dreq();
      chk("R4 preq_valid", preq_valid, 1);
      chk("R4 preq_blk", preq_blk, 32);
      accept_preq();
      chk("R8 issued once", preq_valid, 0);
      do_fill(32);
      chk("R8 no xfer on fill", xfer_valid, 0);
      step();
      chk("R8 still no xfer", xfer_valid, 0);

      // R9: miss on filled entry
      do_miss(32, 0);
      chk("R9 no dreq", dreq_valid, 0);
      chk("R9 xfer_valid", xfer_valid, 1);
      chk("R9 xfer_blk", xfer_blk, 32);
      chk("R4 next preq_blk", preq_blk, 40);
      accept_preq();
      chk("R9 xfer one cycle", xfer_valid, 0);

      // R7: prediction already held in the buffer (pending 40)
      do_miss(39, 1);
      chk("R3 dreq_blk 39", dreq_blk, 39);
      accept_dreq();
      chk("R7 buffer-present no preq", preq_valid, 0);

      // R10: miss on pending entry, transfer after fill
      do_miss(40, 0);
      chk("R10 no dreq", dreq_valid, 0);
      chk("R10 no xfer before fill", xfer_valid, 0);
      do_fill(40);
      chk("R10 xfer_valid", xfer_valid, 1);
      chk("R10 xfer_blk", xfer_blk, 40);
      step();
      chk("R10 xfer one cycle", xfer_valid, 0);

      // R11: FIFO replacement when full
      do_reset();
      for (int k = 0; k < 5; k++) begin
         do_miss(1000 + 10 * k, 1);
         accept_dreq();
         chk("R11 fill-up preq_valid", preq_valid, 1);
         accept_preq();
      end
      do_miss(1001, 1);
      chk("R11 evicted block dreq_valid", dreq_valid, 1);
      chk("R11 evicted block dreq_blk", dreq_blk, 1001);
      accept_dreq();
      do_miss(1011, 1);
      chk("R11 kept block no dreq", dreq_valid, 0);
      step();

      summary();
      $finish;
   end
endmodule